// File: doc/BRIEF.md
# Multi-Column Set-Associative Cache Controller

This block is a read-only lookup controller for a four-way set-associative cache. Each address has one preferred way inside its set, called the home way. The home way is picked by the two address bits just above the set index. The first probe therefore costs the same as a direct-mapped lookup. Other blocks that share the same home way are kept in the remaining ways of the set as overflow ways. Each home way keeps a link vector with one bit per way. The vector records which ways hold its overflow blocks, so a second-chance search only visits those ways.

The controller always keeps the most recently used block of a group in that group's home way. An overflow hit swaps the hit block with the home occupant. A miss fetches the block from lower memory and installs it in the home way. The previous home occupant is pushed into an overflow way. When an install lands on an overflow block that belongs to another group, that block is overwritten and its link bit is cleared.

The FSM has five states:
- `S_IDLE` accepts a request and goes to `S_MAJOR`.
- `S_MAJOR` probes the home way. On a match it returns to `S_IDLE`. If the link vector is non-empty it goes to `S_SEL`, otherwise to `S_FETCH`.
- `S_SEL` probes one linked way per cycle. On a match it goes to `S_SWAP`. If more links remain it stays in `S_SEL`, otherwise it goes to `S_FETCH`.
- `S_SWAP` exchanges the two ways and returns to `S_IDLE`.
- `S_FETCH` holds the memory request until the fill arrives, then returns to `S_IDLE`.

Top module: `mcc_cache_ctrl`

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req`=0, and every way of every set is empty, so any first access is a miss.
- R2: The address fields are: set index = `req_addr[2:0]`, home way = `req_addr[4:3]`, stored tag = `req_addr[15:3]`. Sets are independent of each other.
- R3: When the requested block sits in its home way, the response comes one cycle after acceptance, with `rsp_hit`=1, `rsp_first`=1 and the stored data. `req_ready` is 1 again in the following cycle.
- R4: When no probed way matches, `mem_req`=1 and `mem_addr` equals the request address. Both stay stable until `fill_valid`. The response is given in that fill cycle, with `rsp_hit`=0, `rsp_first`=0 and `rsp_data`=`fill_data`. The new block is then in its home way, so the next access to it is a first hit.
- R5: On a miss, if the home way holds a block of its own group, that block moves to another way and its link bit is set. A later access to it is an overflow hit.
- R6: Linked ways are probed in ascending way order, one per cycle. A match on the k-th probe responds k+1 cycles after acceptance, with `rsp_hit`=1 and `rsp_first`=0. A miss after k probes raises `mem_req` k+2 cycles after acceptance.
- R7: After an overflow hit, one swap cycle follows with `req_ready`=0. After the swap, the hit block answers as a first hit, and the block it displaced answers as an overflow hit.
- R8: The way that receives a displaced home block is chosen in this order, never the home way: the lowest empty way; else the lowest way whose block is outside its own home way; else the lowest other way.
- R9: When an install overwrites an overflow block of another group, that group's link bit for the way is cleared. A later miss in that group probes only its remaining links.
- R10: With an empty link vector, a home-way miss raises `mem_req` two cycles after acceptance, with no overflow probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 16 | Block address of the request |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Response data |
| rsp_hit | output | 1 | Block was found in the cache |
| rsp_first | output | 1 | Block was found in its home way |
| mem_req | output | 1 | Fetch request to lower memory |
| mem_addr | output | 16 | Address of the fetch |
| fill_valid | input | 1 | Fill data is present |
| fill_data | input | 32 | Fill data from lower memory |

## Verification
A corrupted link vector shows up at the ports on the next access to the affected group:
- An extra link stretches the miss latency, because `mem_req` rises a cycle later.
- A lost link turns an expected overflow hit into a miss.

A wrong victim choice or a missed swap shows up a few accesses later. It appears as a first hit where an overflow hit was expected, or the reverse. The stimulus is therefore ordered so that every placement is read back by a later request whose latency and flags pin down which way held the block.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MAJOR,
        S_SEL,
        S_SWAP,
        S_FETCH
    } mcc_state_e;

endpackage

// File: rtl/mcc_line_store.sv
module mcc_line_store #(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             set_i,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
    input  logic                         wa_en,
    input  logic [WAY_W-1:0]             wa_way,
    input  logic                         wa_valid,
    input  logic [TAG_W-1:0]             wa_tag,
    input  logic [DATA_W-1:0]            wa_data,
    input  logic                         wb_en,
    input  logic [WAY_W-1:0]             wb_way,
    input  logic                         wb_valid,
    input  logic [TAG_W-1:0]             wb_tag,
    input  logic [DATA_W-1:0]            wb_data
);

    logic [WAYS-1:0]             val_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
    logic [WAYS-1:0][DATA_W-1:0] data_q [SETS];

    assign rd_valid = val_q[set_i];
    assign rd_tag   = tag_q[set_i];
    assign rd_data  = data_q[set_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s]  <= '0;
                tag_q[s]  <= '0;
                data_q[s] <= '0;
            end
        end else begin
            if (wa_en) begin
                val_q[set_i][wa_way]  <= wa_valid;
                tag_q[set_i][wa_way]  <= wa_tag;
                data_q[set_i][wa_way] <= wa_data;
            end
            if (wb_en) begin
                val_q[set_i][wb_way]  <= wb_valid;
                tag_q[set_i][wb_way]  <= wb_tag;
                data_q[set_i][wb_way] <= wb_data;
            end
        end
    end

    // Both ports never target the same way in one cycle (swap and displace).
    a_r7_ports_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en) |-> (wa_way != wb_way));

endmodule

// File: rtl/mcc_dir_store.sv
module mcc_dir_store #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_W-1:0]               set_i,
    output logic [WAYS-1:0][WAYS-1:0]      rd_vec,
    input  logic                           wr_en,
    input  logic [WAYS-1:0][WAYS-1:0]      wr_vec
);

    // vec_q[set][home way][way] : way holds an overflow block of that home way
    logic [WAYS-1:0][WAYS-1:0] vec_q [SETS];

    assign rd_vec = vec_q[set_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vec_q[s] <= '0;
        end else if (wr_en) begin
            vec_q[set_i] <= wr_vec;
        end
    end

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set
            for (genvar w = 0; w < WAYS; w++) begin : g_way
                // R5: a home way is never linked to itself
                a_r5_no_self_link: assert property (@(posedge clk) disable iff (!rst_n)
                    !vec_q[s][w][w]);
            end
        end
    endgenerate

endmodule

// File: rtl/mcc_victim_sel.sv
module mcc_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAY_W-1:0]            home,
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][WAY_W-1:0]  group,
    output logic [WAY_W-1:0]            victim
);

    logic             have_empty;
    logic             have_foreign;
    logic [WAY_W-1:0] empty_way;
    logic [WAY_W-1:0] foreign_way;
    logic [WAY_W-1:0] other_way;

    // R8: walk downward so the lowest qualifying way is kept
    always_comb begin
        have_empty   = 1'b0;
        have_foreign = 1'b0;
        empty_way    = '0;
        foreign_way  = '0;
        other_way    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (WAY_W'(w) != home) begin
                other_way = WAY_W'(w);
                if (!valid[w]) begin
                    have_empty = 1'b1;
                    empty_way  = WAY_W'(w);
                end else if (group[w] != WAY_W'(w)) begin
                    have_foreign = 1'b1;
                    foreign_way  = WAY_W'(w);
                end
            end
        end
        if (have_empty)        victim = empty_way;
        else if (have_foreign) victim = foreign_way;
        else                   victim = other_way;
    end

endmodule

// File: rtl/mcc_cache_ctrl.sv
module mcc_cache_ctrl
    import mcc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_hit,
    output logic              rsp_first,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);

    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - SET_W;

    function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] m);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) if (m[i]) r = WAY_W'(i);
        return r;
    endfunction

    function automatic logic [WAYS-1:0] onehot(input logic [WAY_W-1:0] i);
        logic [WAYS-1:0] r;
        r    = '0;
        r[i] = 1'b1;
        return r;
    endfunction

    mcc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [WAY_W-1:0]  cur_q, cur_d;
    logic [WAYS-1:0]   rem_q, rem_d;

    // R2: field split of the latched address
    logic [SET_W-1:0] set_idx;
    logic [WAY_W-1:0] home;
    logic [TAG_W-1:0] tag;
    assign set_idx = addr_q[SET_W-1:0];
    assign home    = addr_q[SET_W+WAY_W-1:SET_W];
    assign tag     = addr_q[ADDR_W-1:SET_W];

    logic [WAYS-1:0]              rd_valid;
    logic [WAYS-1:0][TAG_W-1:0]   rd_tag;
    logic [WAYS-1:0][DATA_W-1:0]  rd_data;
    logic [WAYS-1:0][WAYS-1:0]    rd_vec;
    logic [WAYS-1:0][WAYS-1:0]    nv;
    logic                         dir_we;
    logic [WAYS-1:0][WAY_W-1:0]   grp;
    logic [WAYS-1:0]              match;
    logic [WAYS-1:0]              home_links;
    logic [WAY_W-1:0]             vic;
    logic                         displace;

    logic                         wa_en, wa_valid, wb_en, wb_valid;
    logic [WAY_W-1:0]             wa_way, wb_way;
    logic [TAG_W-1:0]             wa_tag, wb_tag;
    logic [DATA_W-1:0]            wa_data, wb_data;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            grp[w]   = rd_tag[w][WAY_W-1:0];
            match[w] = rd_valid[w] && (rd_tag[w] == tag);
        end
    end

    assign home_links = rd_vec[home] & ~onehot(home);
    assign displace   = rd_valid[home] && (grp[home] == home);

    mcc_line_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n), .set_i(set_idx),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
        .wa_en(wa_en), .wa_way(wa_way), .wa_valid(wa_valid), .wa_tag(wa_tag), .wa_data(wa_data),
        .wb_en(wb_en), .wb_way(wb_way), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
    );

    mcc_dir_store #(.SETS(SETS), .WAYS(WAYS)) u_dir (
        .clk(clk), .rst_n(rst_n), .set_i(set_idx),
        .rd_vec(rd_vec), .wr_en(dir_we), .wr_vec(nv)
    );

    mcc_victim_sel #(.WAYS(WAYS)) u_victim (
        .home(home), .valid(rd_valid), .group(grp), .victim(vic)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            cur_q   <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            cur_q   <= cur_d;
            rem_q   <= rem_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        cur_d   = cur_q;
        rem_d   = rem_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    addr_d  = req_addr;
                    state_d = S_MAJOR;
                end
            end
            S_MAJOR: begin
                if (match[home]) begin
                    state_d = S_IDLE;                 // R3
                end else if (home_links != '0) begin
                    cur_d   = lowest(home_links);     // R6
                    rem_d   = home_links & ~onehot(lowest(home_links));
                    state_d = S_SEL;
                end else begin
                    state_d = S_FETCH;                // R10
                end
            end
            S_SEL: begin
                if (match[cur_q]) begin
                    state_d = S_SWAP;
                end else if (rem_q != '0) begin
                    cur_d   = lowest(rem_q);
                    rem_d   = rem_q & ~onehot(lowest(rem_q));
                end else begin
                    state_d = S_FETCH;
                end
            end
            S_SWAP:  state_d = S_IDLE;                // R7
            S_FETCH: if (fill_valid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Array and link updates
    always_comb begin
        wa_en = 1'b0; wa_way = home; wa_valid = 1'b1; wa_tag = tag; wa_data = fill_data;
        wb_en = 1'b0; wb_way = vic;  wb_valid = 1'b1; wb_tag = rd_tag[home]; wb_data = rd_data[home];
        dir_we = 1'b0;
        nv     = rd_vec;
        if (state_q == S_SWAP) begin
            // R7: hit block to home way, home occupant to the hit way
            wa_en    = 1'b1;
            wa_tag   = rd_tag[cur_q];
            wa_data  = rd_data[cur_q];
            wb_en    = 1'b1;
            wb_way   = cur_q;
            wb_valid = rd_valid[home];
            dir_we   = 1'b1;
            nv[home][cur_q] = 1'b0;
            if (rd_valid[home]) begin
                nv[grp[home]][home] = 1'b0;
                if (grp[home] != cur_q) nv[grp[home]][cur_q] = 1'b1;
            end
        end else if (state_q == S_FETCH && fill_valid) begin
            wa_en  = 1'b1;                            // R4
            dir_we = 1'b1;
            if (rd_valid[home] && !displace) begin
                nv[grp[home]][home] = 1'b0;           // R9
            end else if (displace) begin
                wb_en = 1'b1;                         // R5
                if (rd_valid[vic] && grp[vic] != vic) nv[grp[vic]][vic] = 1'b0;   // R9
                nv[home][vic] = 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        mem_req   = (state_q == S_FETCH);
        mem_addr  = addr_q;
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_first = 1'b0;
        rsp_data  = '0;
        unique case (state_q)
            S_MAJOR: if (match[home]) begin
                rsp_valid = 1'b1; rsp_hit = 1'b1; rsp_first = 1'b1; rsp_data = rd_data[home];
            end
            S_SEL: if (match[cur_q]) begin
                rsp_valid = 1'b1; rsp_hit = 1'b1; rsp_data = rd_data[cur_q];
            end
            S_FETCH: if (fill_valid) begin
                rsp_valid = 1'b1; rsp_data = fill_data;
            end
            S_IDLE, S_SWAP: ;
            default: ;
        endcase
    end

    a_r3_first_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_first) |-> rsp_hit);
    a_r4_miss_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (mem_req && fill_valid));
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !fill_valid) |=> (mem_req && $stable(mem_addr)));
    a_r7_swap_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && !rsp_first) |=> (!req_ready && !rsp_valid));
    a_r7_swap_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SWAP) |=> req_ready);
    a_r8_victim_not_home: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && state_q == S_FETCH) |-> (vic != home));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req));

endmodule

// File: tb/mcc_cache_ctrl_tb.sv
module mcc_cache_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int KMISS = 0, KFIRST = 1, KSEL = 2;
    localparam int NVEC = 27;

    // {addr[15:0], kind[1:0], latency[3:0]}
    localparam logic [21:0] VECS [NVEC] = '{
        {16'h0021, 2'd0, 4'd2}, {16'h0021, 2'd1, 4'd1}, {16'h0041, 2'd0, 4'd2},
        {16'h0021, 2'd2, 4'd2}, {16'h0021, 2'd1, 4'd1}, {16'h0041, 2'd2, 4'd2},
        {16'h0061, 2'd0, 4'd3}, {16'h0041, 2'd2, 4'd3}, {16'h0031, 2'd0, 4'd2},
        {16'h0061, 2'd0, 4'd3}, {16'h0051, 2'd0, 4'd2}, {16'h0021, 2'd0, 4'd3},
        {16'h0031, 2'd0, 4'd2}, {16'h0051, 2'd2, 4'd2}, {16'h0051, 2'd1, 4'd1},
        {16'h0022, 2'd0, 4'd2}, {16'h002A, 2'd0, 4'd2}, {16'h0032, 2'd0, 4'd2},
        {16'h003A, 2'd0, 4'd2}, {16'h0042, 2'd0, 4'd2}, {16'h002A, 2'd0, 4'd2},
        {16'h0022, 2'd0, 4'd2}, {16'h0032, 2'd1, 4'd1}, {16'h003A, 2'd1, 4'd1},
        {16'h0042, 2'd2, 4'd2}, {16'h0022, 2'd2, 4'd2}, {16'h0023, 2'd0, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_hit;
    logic        rsp_first;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcc_cache_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_hit(rsp_hit), .rsp_first(rsp_first), .mem_req(mem_req),
        .mem_addr(mem_addr), .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return {~a, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input int kind, input int lat);
        int  n;
        bit  done;
        string rq;
        rq = (kind == KMISS) ? "R4 miss" : (kind == KFIRST) ? "R3 first" : "R6 overflow";
        while (!req_ready) @(negedge clk);
        req_addr  = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n    = 1;
        done = 1'b0;
        while (!done && n < 40) begin
            if (rsp_valid) begin
                check({rq, " kind"}, 32'(kind), (rsp_first ? 32'(KFIRST) : 32'(KSEL)));
                check({rq, " hit"}, 32'(rsp_hit), 32'd1);
                check({rq, " latency R6"}, 32'(n), 32'(lat));
                check({rq, " data"}, rsp_data, mem_word(a));
                @(negedge clk);
                // R7: overflow hit costs one swap cycle before ready
                check({rq, " ready R7"}, 32'(req_ready), (kind == KFIRST) ? 32'd1 : 32'd0);
                done = 1'b1;
            end else if (mem_req) begin
                check({rq, " kind"}, 32'(kind), 32'(KMISS));
                check("R10 R6 R9 fetch latency", 32'(n), 32'(lat));
                check("R4 mem_addr", 32'(mem_addr), 32'(a));
                @(negedge clk);
                @(negedge clk);
                check("R4 request held", {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, a});
                fill_valid = 1'b1;
                fill_data  = mem_word(a);
                #1;
                check("R4 miss response", {29'd0, rsp_valid, rsp_hit, rsp_first}, 32'b100);
                check("R4 fill data", rsp_data, mem_word(a));
                @(negedge clk);
                fill_valid = 1'b0;
                done = 1'b1;
            end else begin
                @(negedge clk);
                n++;
            end
        end
        if (!done) check("access timeout", 32'd0, 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 reset outputs", {29'd0, req_ready, rsp_valid, mem_req}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", 32'(req_ready), 32'd1);

        // Table walk: R2 field split, R3 R4 R5 R6 R7 R8 R9 R10 placements
        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i][21:6], int'(VECS[i][5:4]), int'(VECS[i][3:0]));
        end

        // R2: a block stays reachable after traffic in another set
        access(16'h0023, KFIRST, 1);

        // R1: reset in mid-run empties all ways
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", {29'd0, req_ready, rsp_valid, mem_req}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk);
        access(16'h0051, KMISS, 2);
        access(16'h0051, KFIRST, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule